// File: doc/BRIEF.md
# Posted-Write and Prefetch Target Controller

This block sits on the target side of a bridge between a host bus and a local bus. It decides, on every host data phase, whether to complete the phase (ready), hold it (stall) or tell the host master to come back later (retry). Host writes are posted into a write FIFO and drained to the local side in arrival order. Host reads are served from a read FIFO that the block fills from the local side.

For reads in memory space, the block reads ahead along sequential word addresses. It either stops after a fixed number of words per transaction or keeps the read FIFO topped up continuously. Reads in I/O space are never read ahead: every host data phase becomes exactly one local access. A programmable hold-off timer limits how long any data phase may be stalled before it is turned into a retry.

The local side is a simple word-wide request/acknowledge interface with one access outstanding at a time. Addresses are word addresses.

Top module: `tgt_xfer_ctrl`

## Requirements
- R1: The write FIFO holds 32 entries of address plus 32-bit data. Together with the single local write that may already be in flight, 33 writes are accepted while the local side is stalled. Each accepted write completes (host_ready high) in the first cycle of its data phase.
- R2: With cfg_retry_on_full = 1, a write data phase that meets a full write FIFO gets host_retry in its first cycle.
- R3: With cfg_retry_on_full = 0, a write data phase that meets a full write FIFO is stalled (host_ready low) and ends in a retry from the hold-off timer.
- R4: A read data phase gets host_ready only once its word is in the read FIFO. With an empty FIFO and an immediately acknowledging local side, ready comes in the third cycle of the phase. A memory read burst returns the local words at the start address plus 0, 1, 2 and so on.
- R5: With cfg_prefetch_cont = 0, a memory read transaction issues at most 16 local reads. A data phase beyond the 16th word stalls and is retried.
- R6: With cfg_prefetch_cont = 1, the block keeps fetching while the read FIFO holds fewer than 16 words. After one word has been consumed and the bus has gone idle, 17 local reads have been made.
- R7: When a read transaction ends (a ready phase with host_last high, or a retry), words left unused and any local read still in flight are discarded. The next read returns fresh data from its own address.
- R8: An I/O read (host_io = 1) makes exactly one local read per data phase, at that phase's address, with no read-ahead.
- R9: A stalled data phase is retried in cycle cfg_retry_limit + 1 of the phase. The count restarts with every new data phase. host_ready and host_retry are never high together.
- R10: Posted writes reach the local side in acceptance order with their address and data. A local request holds its address and direction until it is acknowledged.
- R11: A local read is never started while accepted writes are still waiting to reach the local side.
- R12: After reset, host_ready, host_retry and loc_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_retry_on_full | input | 1 | 1: retry writes on a full FIFO; 0: stall them |
| cfg_prefetch_cont | input | 1 | 1: continuous read-ahead; 0: at most 16 words per transaction |
| cfg_retry_limit | input | TW (8) | Stall cycles allowed before a retry |
| host_req | input | 1 | Data phase present |
| host_write | input | 1 | 1: write phase, 0: read phase |
| host_io | input | 1 | 1: I/O space, 0: memory space |
| host_last | input | 1 | Final data phase of the transaction |
| host_addr | input | AW (16) | Word address of the phase |
| host_wdata | input | DW (32) | Write data |
| host_ready | output | 1 | Phase completes this cycle |
| host_retry | output | 1 | Phase is terminated with a retry this cycle |
| host_rdata | output | DW (32) | Read data, valid with host_ready on a read |
| loc_req | output | 1 | Local access request, held until acknowledged |
| loc_we | output | 1 | Local access is a write |
| loc_addr | output | AW (16) | Local word address |
| loc_wdata | output | DW (32) | Local write data |
| loc_ack | input | 1 | Local access completes this cycle |
| loc_rdata | input | DW (32) | Local read data, valid with loc_ack |

## Verification
The assertions assume that the host holds a data phase (request, direction, space, address, data) unchanged until it sees ready or retry. They also assume that the local side raises loc_ack only while loc_req is high. The bench drives host phases from a single task that keeps every input steady until the phase ends. Its local responder acknowledges only a pending request, after a programmable number of wait cycles. All expected data comes from a closed-form function of the local address, and every write is checked against the order in which the host posted it.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

    // Which local access the controller starts in a given cycle.
    typedef enum logic [2:0] {
        ISS_NONE,
        ISS_WR,
        ISS_IO,
        ISS_MEM_NEW,
        ISS_MEM_NEXT
    } issue_e;

endpackage

// File: rtl/tgt_fifo.sv
module tgt_fifo #(
    parameter int W = 32,
    parameter int D = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic [W-1:0]           din,
    input  logic                   pop,
    input  logic                   flush,
    output logic [W-1:0]           dout,
    output logic [$clog2(D+1)-1:0] count,
    output logic                   full,
    output logic                   empty
);
    localparam int PW = $clog2(D);
    localparam int CW = $clog2(D + 1);
    localparam logic [PW-1:0] LAST_PTR = PW'(D - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(D);

    typedef struct packed {
        logic [PW-1:0] rp;
        logic [PW-1:0] wp;
        logic [CW-1:0] cnt;
    } fs_t;

    fs_t f_d, f_q;
    logic [W-1:0] store [D];

    always_comb begin
        f_d = f_q;
        if (flush) begin
            f_d = '0;
        end else begin
            if (push) f_d.wp = (f_q.wp == LAST_PTR) ? '0 : f_q.wp + 1'b1;
            if (pop)  f_d.rp = (f_q.rp == LAST_PTR) ? '0 : f_q.rp + 1'b1;
            f_d.cnt = f_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) store[f_q.wp] <= din;
    end

    assign dout  = store[f_q.rp];
    assign count = f_q.cnt;
    assign full  = (f_q.cnt == FULL_CNT);
    assign empty = (f_q.cnt == '0);

    assert_fifo_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> !full);

    assert_fifo_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> !empty);

endmodule

// File: rtl/tgt_retry_timer.sv
module tgt_retry_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          waiting,
    input  logic          done,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    // Counts stalled cycles of the current phase; any end of phase or
    // idle cycle brings it back to zero for the next phase.
    always_comb begin
        cnt_d = '0;
        if (waiting && !done) cnt_d = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/tgt_xfer_ctrl.sv
module tgt_xfer_ctrl
    import tgt_pkg::*;
#(
    parameter int DW       = 32,
    parameter int AW       = 16,
    parameter int WR_DEPTH = 32,
    parameter int RD_DEPTH = 16,
    parameter int TW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_retry_on_full,
    input  logic          cfg_prefetch_cont,
    input  logic [TW-1:0] cfg_retry_limit,
    input  logic          host_req,
    input  logic          host_write,
    input  logic          host_io,
    input  logic          host_last,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ready,
    output logic          host_retry,
    output logic [DW-1:0] host_rdata,
    output logic          loc_req,
    output logic          loc_we,
    output logic [AW-1:0] loc_addr,
    output logic [DW-1:0] loc_wdata,
    input  logic          loc_ack,
    input  logic [DW-1:0] loc_rdata
);
    localparam int WCW = $clog2(WR_DEPTH + 1);
    localparam int RCW = $clog2(RD_DEPTH + 1);
    localparam int WEW = AW + DW;
    localparam logic [RCW-1:0] RD_CAP = RCW'(RD_DEPTH);

    typedef struct packed {
        logic          busy;
        logic          op_we;
        logic [AW-1:0] op_addr;
        logic [DW-1:0] op_data;
        logic          keep;
        logic          stream;
        logic [AW-1:0] pf_addr;
        logic [RCW-1:0] pf_cnt;
        logic          io_got;
    } st_t;

    st_t    s_d, s_q;
    issue_e sel;

    logic           wr_phase, rd_phase, rd_end, tmr_expired;
    logic           wf_push, wf_pop, wf_full, wf_empty;
    logic [WEW-1:0] wf_dout;
    logic [WCW-1:0] wf_count;
    logic           rf_push, rf_pop, rf_full, rf_empty;
    logic [DW-1:0]  rf_dout;
    logic [RCW-1:0] rf_count;

    tgt_fifo #(.W(WEW), .D(WR_DEPTH)) u_wfifo (
        .clk(clk), .rst_n(rst_n), .push(wf_push), .din({host_addr, host_wdata}),
        .pop(wf_pop), .flush(1'b0), .dout(wf_dout), .count(wf_count),
        .full(wf_full), .empty(wf_empty)
    );

    tgt_fifo #(.W(DW), .D(RD_DEPTH)) u_rfifo (
        .clk(clk), .rst_n(rst_n), .push(rf_push), .din(loc_rdata),
        .pop(rf_pop), .flush(rd_end), .dout(rf_dout), .count(rf_count),
        .full(rf_full), .empty(rf_empty)
    );

    tgt_retry_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .waiting(host_req && !host_ready),
        .done(host_retry), .limit(cfg_retry_limit), .expired(tmr_expired)
    );

    // Host-side response for the current data phase.
    always_comb begin
        wr_phase   = host_req && host_write;
        rd_phase   = host_req && !host_write;
        host_ready = (wr_phase && !wf_full) || (rd_phase && !rf_empty);
        host_retry = host_req && !host_ready &&
                     (tmr_expired || (wr_phase && wf_full && cfg_retry_on_full));
        rd_end     = rd_phase && ((host_ready && host_last) || host_retry);
        host_rdata = rf_dout;
    end

    // Next-state logic for the local access engine.
    always_comb begin
        s_d = s_q;
        sel = ISS_NONE;
        if (s_q.busy && loc_ack) s_d.busy = 1'b0;

        if (!s_q.busy) begin
            if (!wf_empty)
                sel = ISS_WR;
            else if (rd_phase && host_io && rf_empty && !s_q.io_got && !host_retry)
                sel = ISS_IO;
            else if (rd_phase && !host_io && !s_q.stream && !host_retry)
                sel = ISS_MEM_NEW;
            else if (s_q.stream && !rd_end && rf_count < RD_CAP &&
                     (cfg_prefetch_cont || s_q.pf_cnt < RD_CAP))
                sel = ISS_MEM_NEXT;
        end

        case (sel)
            ISS_WR: begin
                s_d.busy    = 1'b1;
                s_d.op_we   = 1'b1;
                s_d.op_addr = wf_dout[WEW-1:DW];
                s_d.op_data = wf_dout[DW-1:0];
                s_d.keep    = 1'b0;
            end
            ISS_IO: begin
                s_d.busy    = 1'b1;
                s_d.op_we   = 1'b0;
                s_d.op_addr = host_addr;
                s_d.keep    = 1'b1;
                s_d.io_got  = 1'b1;
            end
            ISS_MEM_NEW: begin
                s_d.busy    = 1'b1;
                s_d.op_we   = 1'b0;
                s_d.op_addr = host_addr;
                s_d.keep    = 1'b1;
                s_d.stream  = 1'b1;
                s_d.pf_addr = host_addr + 1'b1;
                s_d.pf_cnt  = RCW'(1);
            end
            ISS_MEM_NEXT: begin
                s_d.busy    = 1'b1;
                s_d.op_we   = 1'b0;
                s_d.op_addr = s_q.pf_addr;
                s_d.keep    = 1'b1;
                s_d.pf_addr = s_q.pf_addr + 1'b1;
                if (s_q.pf_cnt != RD_CAP) s_d.pf_cnt = s_q.pf_cnt + 1'b1;
            end
            default: ;
        endcase

        if (rd_end) begin
            s_d.stream = 1'b0;
            s_d.keep   = 1'b0;
        end
        if (rd_phase && (host_ready || host_retry)) s_d.io_got = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wf_push   = wr_phase && host_ready;
    assign wf_pop    = (sel == ISS_WR);
    assign rf_push   = s_q.busy && loc_ack && !s_q.op_we && s_q.keep && !rd_end;
    assign rf_pop    = rd_phase && host_ready;
    assign loc_req   = s_q.busy;
    assign loc_we    = s_q.op_we;
    assign loc_addr  = s_q.op_addr;
    assign loc_wdata = s_q.op_data;

    assert_loc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req && !loc_ack) |=> (loc_req && $stable(loc_addr) && $stable(loc_we)));

    assert_read_after_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(loc_req) && !loc_we) |-> $past(wf_empty));

    assert_ready_retry_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ready && host_retry));

    assert_flush_on_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_phase && host_retry) |=> rf_empty);

endmodule

// File: tb/tgt_xfer_ctrl_test.sv
`timescale 1ns/1ps
module tgt_xfer_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_retry_on_full = 1'b0;
    logic        cfg_prefetch_cont = 1'b0;
    logic [7:0]  cfg_retry_limit = 8'd200;
    logic        host_req = 1'b0, host_write = 1'b0, host_io = 1'b0, host_last = 1'b0;
    logic [15:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, host_retry;
    logic [31:0] host_rdata;
    logic        loc_req, loc_we;
    logic [15:0] loc_addr;
    logic [31:0] loc_wdata;
    logic        loc_ack = 1'b0;
    logic [31:0] loc_rdata = '0;

    int checks = 0, failures = 0;
    int lat = 0, wcnt = 0;
    int writes_acc = 0, writes_seen = 0, loc_reads = 0;
    logic [15:0] exp_wa [64];
    logic [31:0] exp_wd [64];
    logic [15:0] rd_log [64];

    always #10 clk = ~clk;

    tgt_xfer_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_retry_on_full(cfg_retry_on_full),
        .cfg_prefetch_cont(cfg_prefetch_cont), .cfg_retry_limit(cfg_retry_limit),
        .host_req(host_req), .host_write(host_write), .host_io(host_io),
        .host_last(host_last), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_retry(host_retry), .host_rdata(host_rdata),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_ack(loc_ack), .loc_rdata(loc_rdata)
    );

    function automatic logic [31:0] lword(input logic [15:0] a);
        return 32'h5A00_0000 + {16'h0, a} * 3;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Local-side responder: acknowledges after lat wait cycles.
    always @(negedge clk) begin
        if (rst_n && loc_req) begin
            if (wcnt >= lat) begin
                loc_ack = 1'b1;
                loc_rdata = lword(loc_addr);
                wcnt = 0;
                if (loc_we) begin
                    check(loc_addr == exp_wa[writes_seen % 64], "R10 write addr order", loc_addr, exp_wa[writes_seen % 64]);
                    check(loc_wdata == exp_wd[writes_seen % 64], "R10 write data order", loc_wdata, exp_wd[writes_seen % 64]);
                    writes_seen++;
                end else begin
                    check(writes_seen == writes_acc, "R11 read waits for drain", writes_seen, writes_acc);
                    rd_log[loc_reads % 64] = loc_addr;
                    loc_reads++;
                end
            end else begin
                loc_ack = 1'b0;
                wcnt++;
            end
        end else begin
            loc_ack = 1'b0;
            wcnt = 0;
        end
    end

    task automatic phase(input logic we, input logic io, input logic last,
                         input logic [15:0] a, input logic [31:0] d,
                         output int cyc, output logic rdy, output logic [31:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_write = we; host_io = io; host_last = last;
        host_addr = a; host_wdata = d;
        cyc = 0; rdy = 1'b0; rd = '0;
        for (int k = 0; k < 3000; k++) begin
            #1;
            cyc++;
            if (host_ready || host_retry) begin
                rdy = host_ready;
                rd = host_rdata;
                break;
            end
            @(negedge clk);
        end
        if (rdy && we) begin
            exp_wa[writes_acc % 64] = a;
            exp_wd[writes_acc % 64] = d;
            writes_acc++;
        end
        @(posedge clk);
        #1;
        host_req = 1'b0; host_last = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cyc, base;
        logic rdy;
        logic [31:0] rd;

        idle(3);
        check(!host_ready && !host_retry && !loc_req, "R12 reset outputs", {host_ready, host_retry, loc_req}, 0);
        rst_n = 1'b1;
        idle(2);
        check(!host_ready && !host_retry && !loc_req, "R12 idle after reset", {host_ready, host_retry, loc_req}, 0);

        // R1: fill with the local side stalled
        lat = 100000;
        for (int i = 0; i < 33; i++) begin
            phase(1'b1, 1'b0, 1'b1, 16'h0040 + 16'(i), 32'hA500_0000 + 32'(i * 7), cyc, rdy, rd);
            check(rdy && cyc == 1, "R1 write accepted in first cycle", cyc, 1);
        end
        // R3 / R9: stall policy, limit 5, twice to show the count restarts
        cfg_retry_limit = 8'd5;
        phase(1'b1, 1'b0, 1'b1, 16'h00F0, 32'hDEAD_0001, cyc, rdy, rd);
        check(!rdy && cyc == 6, "R3 stalled write retried by timer", cyc, 6);
        phase(1'b1, 1'b0, 1'b1, 16'h00F1, 32'hDEAD_0002, cyc, rdy, rd);
        check(!rdy && cyc == 6, "R9 timer restarts each phase", cyc, 6);
        // R2: retry policy
        cfg_retry_on_full = 1'b1;
        phase(1'b1, 1'b0, 1'b1, 16'h00F2, 32'hDEAD_0003, cyc, rdy, rd);
        check(!rdy && cyc == 1, "R2 full write retried at once", cyc, 1);
        cfg_retry_on_full = 1'b0;
        cfg_retry_limit = 8'd200;
        // R10: drain
        lat = 0;
        idle(150);
        check(writes_seen == 33, "R10 all posted writes drained", writes_seen, 33);

        // R11: writes pending when a read arrives
        lat = 4;
        for (int i = 0; i < 3; i++)
            phase(1'b1, 1'b0, 1'b1, 16'h0200 + 16'(i), 32'hB000_0000 + 32'(i), cyc, rdy, rd);
        phase(1'b0, 1'b0, 1'b1, 16'h0300, '0, cyc, rdy, rd);
        check(rdy && rd == lword(16'h0300), "R11 read after writes data", rd, lword(16'h0300));
        check(writes_seen == 36, "R11 writes done before read", writes_seen, 36);
        lat = 0;
        idle(20);

        // R5: bounded prefetch
        cfg_prefetch_cont = 1'b0;
        base = loc_reads;
        phase(1'b0, 1'b0, 1'b0, 16'h1000, '0, cyc, rdy, rd);
        check(rdy && rd == lword(16'h1000), "R4 first memory word", rd, lword(16'h1000));
        idle(60);
        check(loc_reads - base == 16, "R5 prefetch capped at 16", loc_reads - base, 16);
        for (int i = 1; i < 16; i++) begin
            phase(1'b0, 1'b0, 1'b0, 16'h1000 + 16'(i), '0, cyc, rdy, rd);
            check(rdy && rd == lword(16'h1000 + 16'(i)), "R4 sequential memory word", rd, lword(16'h1000 + 16'(i)));
        end
        cfg_retry_limit = 8'd10;
        phase(1'b0, 1'b0, 1'b0, 16'h1010, '0, cyc, rdy, rd);
        check(!rdy && cyc == 11, "R5 word past cap retried", cyc, 11);
        cfg_retry_limit = 8'd200;
        idle(10);
        check(loc_reads - base == 16, "R5 no read beyond cap", loc_reads - base, 16);

        // R4 / R7: fresh transaction after a discard
        phase(1'b0, 1'b0, 1'b1, 16'h2000, '0, cyc, rdy, rd);
        check(rdy && cyc == 3, "R4 ready in third cycle", cyc, 3);
        check(rd == lword(16'h2000), "R7 no stale data", rd, lword(16'h2000));
        idle(60);

        // R6: continuous prefetch
        cfg_prefetch_cont = 1'b1;
        base = loc_reads;
        phase(1'b0, 1'b0, 1'b0, 16'h3000, '0, cyc, rdy, rd);
        idle(60);
        check(loc_reads - base == 17, "R6 continuous refill", loc_reads - base, 17);
        for (int i = 1; i <= 20; i++) begin
            phase(1'b0, 1'b0, i == 20, 16'h3000 + 16'(i), '0, cyc, rdy, rd);
            check(rdy && rd == lword(16'h3000 + 16'(i)), "R6 continuous word", rd, lword(16'h3000 + 16'(i)));
        end
        cfg_prefetch_cont = 1'b0;
        idle(20);

        // R8: I/O reads
        base = loc_reads;
        phase(1'b0, 1'b1, 1'b0, 16'h0050, '0, cyc, rdy, rd);
        check(rdy && rd == lword(16'h0050), "R8 io word 0", rd, lword(16'h0050));
        phase(1'b0, 1'b1, 1'b0, 16'h0077, '0, cyc, rdy, rd);
        check(rdy && rd == lword(16'h0077), "R8 io word 1", rd, lword(16'h0077));
        phase(1'b0, 1'b1, 1'b1, 16'h0013, '0, cyc, rdy, rd);
        check(rdy && rd == lword(16'h0013), "R8 io word 2", rd, lword(16'h0013));
        idle(20);
        check(loc_reads - base == 3, "R8 one local read per phase", loc_reads - base, 3);
        check(rd_log[(base + 1) % 64] == 16'h0077, "R8 io address", rd_log[(base + 1) % 64], 16'h0077);

        // R9: read stall turned into retry, late word discarded (R7)
        lat = 100;
        cfg_retry_limit = 8'd3;
        phase(1'b0, 1'b0, 1'b0, 16'h4000, '0, cyc, rdy, rd);
        check(!rdy && cyc == 4, "R9 read stall retried", cyc, 4);
        lat = 0;
        cfg_retry_limit = 8'd200;
        idle(150);
        phase(1'b0, 1'b0, 1'b1, 16'h4100, '0, cyc, rdy, rd);
        check(rdy && rd == lword(16'h4100), "R7 late word dropped", rd, lword(16'h4100));
        idle(20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule